// File: doc/BRIEF.md
# Interrupt Distributor Register Bank

This block is the software-visible register file of a shared interrupt distributor. It sits on a 32-bit register bus with byte strobes. Each enabled byte lane is decoded as its own byte access, and all lanes of a word are handled in the same cycle. The bus also carries the number of the CPU making the access, so per-CPU views and per-CPU forcing can be applied on that access.

The block holds the global distribution switch and, for every interrupt ID, an enable bit, a priority byte, a CPU target mask and a two-bit configuration (model and edge trigger). The pending and active flags are kept by the neighbouring selector. This block reads them through input vectors and asks the selector to change pending state through one-cycle set and clear request vectors. A software-interrupt trigger word and a read-only identification area complete the map. Any access that falls on a hole, on a read-only bank, or on an ID at or above the configured count raises a bad-address flag and changes nothing.

Top module: `irq_dist_regs`

## Requirements
- R1: After reset the switch is off, IDs 0 to 15 are enabled and edge-triggered (their config bytes read 0xAA), every other ID is disabled and level-triggered with model 0, and all priorities and targets are zero.
- R2: Byte offset 0x000 bit 0 holds the distribution switch and drives `dist_en`; bytes 0x001 to 0x003 ignore writes and read zero; the word at 0x004 reads (NIRQ/32-1) | ((NCPU-1)<<5).
- R3: A write to 0x100+n sets the enable of IDs 8n..8n+7 for each one bit; a write to 0x180+n clears them. A set-enable byte covering IDs below 16 acts as 0xFF, and a clear-enable byte covering them has no effect.
- R4: When set-enable turns on a level-triggered ID whose `irq_level` input is high, the same cycle raises a set request for that ID: to the writing CPU for IDs below 32, otherwise to the ID's target mask. Edge-triggered IDs raise none.
- R5: A one bit written to 0x200+n requests pending for ID 8n+bit (writer's CPU below ID 32, target mask otherwise); a one bit written to 0x280+n drives the all-CPU clear request for that ID. Requests exist only in the write cycle.
- R6: Reads of the pending bank (0x200/0x280) and active bank (0x300) show, for IDs below 32, the reading CPU's own bit, and for higher IDs the OR over all CPUs.
- R7: Byte 0x400+i holds the priority of ID i and reads back what was written.
- R8: Target byte 0x800+i stores the low NCPU bits of the write for IDs from 32; writes store 0 for IDs below 29 and all CPUs for IDs 29 to 31; reads of IDs 29 to 31 return only the reader's bit.
- R9: Config byte 0xC00+n covers IDs 4n..4n+3, two bits each with the lower ID in the lower bits: bit 0 selects the 1-of-N model, bit 1 selects edge. Bytes covering IDs below 32 are written ORed with 0xAA.
- R10: A full-word write to 0xF00 requests pending for the ID in bits 9:0, with bits 25:24 picking the CPUs: 0 the list in bits 23:16, 1 the writer, 2 all but the writer, 3 all CPUs.
- R11: Word offsets 0xFE0 to 0xFFC read the identification bytes 0x90, 0x13, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in lane 0; lanes 1 to 3 in that range read zero.
- R12: An access whose enabled lanes include a write to the active bank, the type word or the identification area, any access to 0x008 to 0x0FF, an ID at or above NIRQ, a read of 0x0F00 to 0x0FDF, or anything at 0xF00 other than a full-word write of an ID below NIRQ raises `acc_bad`, reads zero, and alters no state and raises no request.
- R13: Lanes with a clear strobe neither read nor write, and several lanes of one word take effect together in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Access valid this cycle |
| acc_wr | input | 1 | 1 write, 0 read |
| acc_waddr | input | 10 | Word address (byte offset bits 11:2) |
| acc_be | input | 4 | Byte lane strobes |
| acc_wdata | input | 32 | Write data |
| acc_cpu | input | CW | CPU number of the access |
| acc_rdata | output | 32 | Read data, valid during a read access |
| acc_bad | output | 1 | Bad-address flag for the current access |
| irq_level | input | NIRQ | Current level of each interrupt input |
| pend_state | input | NIRQ*NCPU | Pending flags from the selector, bit id*NCPU+cpu |
| act_state | input | NIRQ*NCPU | Active flags from the selector, bit id*NCPU+cpu |
| dist_en | output | 1 | Distribution switch |
| irq_enable | output | NIRQ | Per-ID enable |
| irq_model | output | NIRQ | Per-ID 1-of-N model bit |
| irq_edge | output | NIRQ | Per-ID edge-trigger bit |
| irq_target | output | NIRQ*NCPU | Per-ID CPU target mask |
| irq_prio | output | NIRQ*8 | Per-ID priority byte |
| pend_set | output | NIRQ*NCPU | One-cycle pending set request |
| pend_clr | output | NIRQ | One-cycle all-CPU pending clear request |

## Verification
The two functions that meet in a single cycle are the enable update and the level-driven pending request: a set-enable write turns an ID on and, in that same cycle, must present a set request if the line is already high and the ID is level-triggered. This is provoked by holding two level inputs high and writing a set-enable word that covers both IDs, then judging the request vector sampled inside the write cycle against the target masks, and the enable readback on the following access. The edge case is repeated after the config write forces edge mode, where the same enable write must raise no request.

// File: rtl/irq_dist_regs.sv
module irq_dist_regs #(
  parameter int NIRQ = 64,
  parameter int NCPU = 4,
  localparam int CW = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 acc_en,
  input  logic                 acc_wr,
  input  logic [9:0]           acc_waddr,
  input  logic [3:0]           acc_be,
  input  logic [31:0]          acc_wdata,
  input  logic [CW-1:0]        acc_cpu,
  output logic [31:0]          acc_rdata,
  output logic                 acc_bad,
  input  logic [NIRQ-1:0]      irq_level,
  input  logic [NIRQ*NCPU-1:0] pend_state,
  input  logic [NIRQ*NCPU-1:0] act_state,
  output logic                 dist_en,
  output logic [NIRQ-1:0]      irq_enable,
  output logic [NIRQ-1:0]      irq_model,
  output logic [NIRQ-1:0]      irq_edge,
  output logic [NIRQ*NCPU-1:0] irq_target,
  output logic [NIRQ*8-1:0]    irq_prio,
  output logic [NIRQ*NCPU-1:0] pend_set,
  output logic [NIRQ-1:0]      pend_clr
);

  localparam logic [31:0] TYPE_WORD = 32'(NIRQ / 32 - 1) | (32'(NCPU - 1) << 5);

  function automatic logic [7:0] ident(input int k);
    case (k)
      0: return 8'h90;
      1: return 8'h13;
      2: return 8'h04;
      3: return 8'h00;
      4: return 8'h0D;
      5: return 8'hF0;
      6: return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction

  function automatic logic view(input logic [NIRQ*NCPU-1:0] st, input int i,
                                input logic [CW-1:0] c);
    if (i < 32) return st[i*NCPU + int'(c)];
    return |st[i*NCPU +: NCPU];
  endfunction

  logic                 en_q, en_d;
  logic [NIRQ-1:0]      ena_q, ena_d, model_q, model_d, edge_q, edge_d;
  logic [7:0]           prio_q [NIRQ];
  logic [7:0]           prio_d [NIRQ];
  logic [NCPU-1:0]      tgt_q [NIRQ];
  logic [NCPU-1:0]      tgt_d [NIRQ];
  logic [NCPU-1:0]      self_m, sgi_m;
  logic                 sgi_hit, bad;
  logic [31:0]          rd;
  logic [NIRQ*NCPU-1:0] set_r;
  logic [NIRQ-1:0]      clr_r;
  int                   o, id;
  logic [7:0]           v, wb;
  logic                 lb;

  assign self_m  = NCPU'(1) << acc_cpu;
  assign sgi_hit = acc_wr && acc_be == 4'hF && acc_waddr == 10'h3C0 &&
                   acc_wdata[9:0] < 10'(NIRQ);

  always_comb begin
    case (acc_wdata[25:24])
      2'd0:    sgi_m = acc_wdata[16 +: NCPU];
      2'd1:    sgi_m = self_m;
      2'd2:    sgi_m = ~self_m;
      default: sgi_m = '1;
    endcase
  end

  always_comb begin
    bad = 1'b0;
    rd  = '0;
    o = 0; id = 0; v = '0; wb = '0; lb = 1'b0;
    en_d = en_q; ena_d = ena_q; model_d = model_q; edge_d = edge_q;
    prio_d = prio_q; tgt_d = tgt_q;
    set_r = '0; clr_r = '0;

    for (int l = 0; l < 4; l++) begin
      o  = int'({acc_waddr, 2'(l)});
      v  = '0;
      lb = 1'b0;
      if (o < 'h100) begin
        if (o == 0) v = {7'b0, en_q};
        else if (o >= 4 && o < 8) begin
          v  = TYPE_WORD[8*(o-4) +: 8];
          lb = acc_wr;
        end else if (o >= 8) lb = 1'b1;
      end else if (o < 'h300) begin
        id = (o & 'h7F) * 8;
        if (id >= NIRQ) lb = 1'b1;
        else for (int b = 0; b < 8; b++)
          v[b] = (o < 'h200) ? ena_q[id+b] : view(pend_state, id + b, acc_cpu);
      end else if (o < 'h400) begin
        id = (o - 'h300) * 8;
        if (id >= NIRQ || acc_wr) lb = 1'b1;
        else for (int b = 0; b < 8; b++) v[b] = view(act_state, id + b, acc_cpu);
      end else if (o < 'h800) begin
        id = o - 'h400;
        if (id >= NIRQ) lb = 1'b1;
        else v = prio_q[id];
      end else if (o < 'hC00) begin
        id = o - 'h800;
        if (id >= NIRQ) lb = 1'b1;
        else if (id >= 29 && id < 32) v = 8'(self_m);
        else v = 8'(tgt_q[id]);
      end else if (o < 'hF00) begin
        id = (o - 'hC00) * 4;
        if (id >= NIRQ) lb = 1'b1;
        else for (int b = 0; b < 4; b++) begin
          v[2*b]   = model_q[id+b];
          v[2*b+1] = edge_q[id+b];
        end
      end else if (o < 'hFE0) lb = !sgi_hit;
      else if (acc_wr) lb = 1'b1;
      else if ((o & 3) == 0) v = ident((o - 'hFE0) >> 2);
      if (acc_be[l]) begin
        bad = bad | lb;
        rd[8*l +: 8] = v;
      end
    end
    if (!acc_en) bad = 1'b0;
    if (bad || acc_wr || !acc_en) rd = '0;

    if (acc_en && acc_wr && !bad) begin
      for (int l = 0; l < 4; l++) begin
        if (acc_be[l]) begin
          o  = int'({acc_waddr, 2'(l)});
          wb = acc_wdata[8*l +: 8];
          if (o == 0) en_d = wb[0];
          else if (o >= 'h100 && o < 'h300) begin
            id = (o & 'h7F) * 8;
            if (o < 'h180) begin
              if (id < 16) wb = 8'hFF;
              for (int b = 0; b < 8; b++) if (wb[b]) begin
                ena_d[id+b] = 1'b1;
                if (irq_level[id+b] && !edge_q[id+b])
                  set_r[(id+b)*NCPU +: NCPU] |= (id + b < 32) ? self_m : tgt_q[id+b];
              end
            end else if (o < 'h200) begin
              if (id >= 16)
                for (int b = 0; b < 8; b++) if (wb[b]) ena_d[id+b] = 1'b0;
            end else if (o < 'h280) begin
              for (int b = 0; b < 8; b++) if (wb[b])
                set_r[(id+b)*NCPU +: NCPU] |= (id + b < 32) ? self_m : tgt_q[id+b];
            end else begin
              for (int b = 0; b < 8; b++) if (wb[b]) clr_r[id+b] = 1'b1;
            end
          end else if (o >= 'h400 && o < 'h800) prio_d[o-'h400] = wb;
          else if (o >= 'h800 && o < 'hC00) begin
            id = o - 'h800;
            tgt_d[id] = (id < 29) ? '0 : (id < 32) ? '1 : wb[NCPU-1:0];
          end else if (o >= 'hC00 && o < 'hF00) begin
            id = (o - 'hC00) * 4;
            if (id < 32) wb = wb | 8'hAA;
            for (int b = 0; b < 4; b++) begin
              model_d[id+b] = wb[2*b];
              edge_d[id+b]  = wb[2*b+1];
            end
          end
        end
      end
      if (sgi_hit) set_r[int'(acc_wdata[9:0])*NCPU +: NCPU] |= sgi_m;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      ena_q   <= {{(NIRQ-16){1'b0}}, 16'hFFFF};
      edge_q  <= {{(NIRQ-16){1'b0}}, 16'hFFFF};
      model_q <= '0;
      prio_q  <= '{default: '0};
      tgt_q   <= '{default: '0};
    end else begin
      en_q    <= en_d;
      ena_q   <= ena_d;
      edge_q  <= edge_d;
      model_q <= model_d;
      prio_q  <= prio_d;
      tgt_q   <= tgt_d;
    end
  end

  for (genvar i = 0; i < NIRQ; i++) begin : g_flat
    assign irq_prio[8*i +: 8]         = prio_q[i];
    assign irq_target[NCPU*i +: NCPU] = tgt_q[i];
  end

  assign acc_rdata  = rd;
  assign acc_bad    = bad;
  assign dist_en    = en_q;
  assign irq_enable = ena_q;
  assign irq_model  = model_q;
  assign irq_edge   = edge_q;
  assign pend_set   = set_r;
  assign pend_clr   = clr_r;

endmodule

// File: rtl/irq_dist_regs_chk.sv
module irq_dist_regs_chk #(
  parameter int NIRQ = 64,
  parameter int NCPU = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 acc_en,
  input logic                 acc_wr,
  input logic                 acc_bad,
  input logic                 dist_en,
  input logic [NIRQ-1:0]      irq_enable,
  input logic [NIRQ-1:0]      irq_edge,
  input logic [NIRQ*NCPU-1:0] irq_target,
  input logic [NIRQ*8-1:0]    irq_prio,
  input logic [NIRQ*NCPU-1:0] pend_set,
  input logic [NIRQ-1:0]      pend_clr
);

  p_bad_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_bad) |-> (pend_set == '0 && pend_clr == '0));

  p_bad_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_wr && acc_bad) |=> ($stable(irq_enable) && $stable(dist_en) &&
      $stable(irq_edge) && $stable(irq_prio) && $stable(irq_target)));

  p_low_enabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_enable[15:0] == 16'hFFFF);

  p_low_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_edge[15:0] == 16'hFFFF);

  p_private_tgt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_target[29*NCPU-1:0] == '0);

  p_req_on_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_set != '0 || pend_clr != '0) |-> (acc_en && acc_wr));

  p_switch_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_en && acc_wr) |=> $stable(dist_en));

endmodule

bind irq_dist_regs irq_dist_regs_chk #(.NIRQ(NIRQ), .NCPU(NCPU)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr), .acc_bad(acc_bad),
  .dist_en(dist_en), .irq_enable(irq_enable), .irq_edge(irq_edge),
  .irq_target(irq_target), .irq_prio(irq_prio), .pend_set(pend_set),
  .pend_clr(pend_clr)
);

// File: tb/sim_irq_dist_regs.sv
module sim_irq_dist_regs;
  localparam int NIRQ = 64;
  localparam int NCPU = 4;
  localparam int NT   = 34;

  logic clk = 1'b0, rst_n = 1'b0;
  logic acc_en = 1'b0, acc_wr = 1'b0;
  logic [9:0] acc_waddr = '0;
  logic [3:0] acc_be = '0;
  logic [31:0] acc_wdata = '0;
  logic [1:0] acc_cpu = '0;
  logic [31:0] acc_rdata;
  logic acc_bad;
  logic [NIRQ-1:0] irq_level = '0;
  logic [NIRQ*NCPU-1:0] pend_state = '0, act_state = '0;
  logic dist_en;
  logic [NIRQ-1:0] irq_enable, irq_model, irq_edge, pend_clr;
  logic [NIRQ*NCPU-1:0] irq_target, pend_set;
  logic [NIRQ*8-1:0] irq_prio;

  logic [31:0] s_rd;
  logic s_bad;
  logic [NIRQ*NCPU-1:0] s_set;
  logic [NIRQ-1:0] s_clr;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_dist_regs #(.NIRQ(NIRQ), .NCPU(NCPU)) u0 (.*);

  // {wr, byte addr, be, wdata, cpu, expected rdata, expected bad}
  localparam logic [83:0] TBL [NT] = '{
    {1'b0,12'h000,4'hF,32'h0,2'd0,32'h00000000,1'b0}, // R1
    {1'b0,12'h004,4'hF,32'h0,2'd0,32'h00000061,1'b0}, // R2
    {1'b0,12'h100,4'hF,32'h0,2'd0,32'h0000FFFF,1'b0}, // R1
    {1'b0,12'hC00,4'hF,32'h0,2'd0,32'hAAAAAAAA,1'b0}, // R1
    {1'b1,12'h000,4'h1,32'h1,2'd0,32'h0,1'b0},        // R2
    {1'b0,12'h000,4'hF,32'h0,2'd0,32'h00000001,1'b0}, // R2
    {1'b1,12'h180,4'hF,32'hFFFFFFFF,2'd0,32'h0,1'b0}, // R3
    {1'b0,12'h100,4'hF,32'h0,2'd0,32'h0000FFFF,1'b0}, // R3
    {1'b1,12'h104,4'hF,32'h80000001,2'd0,32'h0,1'b0}, // R3
    {1'b0,12'h104,4'hF,32'h0,2'd0,32'h80000001,1'b0}, // R3
    {1'b1,12'h184,4'h1,32'h00000001,2'd0,32'h0,1'b0}, // R13
    {1'b0,12'h104,4'hF,32'h0,2'd0,32'h80000000,1'b0}, // R13
    {1'b1,12'h404,4'hF,32'h44332211,2'd0,32'h0,1'b0}, // R7
    {1'b0,12'h404,4'hF,32'h0,2'd0,32'h44332211,1'b0}, // R7
    {1'b1,12'h404,4'h4,32'h00AA0000,2'd0,32'h0,1'b0}, // R13
    {1'b0,12'h404,4'hF,32'h0,2'd0,32'h44AA2211,1'b0}, // R13
    {1'b1,12'h820,4'hF,32'hFFFFFFFF,2'd0,32'h0,1'b0}, // R8
    {1'b0,12'h820,4'hF,32'h0,2'd0,32'h0F0F0F0F,1'b0}, // R8
    {1'b1,12'h81C,4'hF,32'hFFFFFFFF,2'd0,32'h0,1'b0}, // R8
    {1'b0,12'h81C,4'hF,32'h0,2'd2,32'h04040400,1'b0}, // R8
    {1'b1,12'hC08,4'hF,32'h00000055,2'd0,32'h0,1'b0}, // R9
    {1'b0,12'hC08,4'hF,32'h0,2'd0,32'h00000055,1'b0}, // R9
    {1'b0,12'hFE0,4'hF,32'h0,2'd0,32'h00000090,1'b0}, // R11
    {1'b0,12'hFE4,4'hF,32'h0,2'd0,32'h00000013,1'b0}, // R11
    {1'b0,12'hFF4,4'hF,32'h0,2'd0,32'h000000F0,1'b0}, // R11
    {1'b0,12'hFFC,4'hF,32'h0,2'd0,32'h000000B1,1'b0}, // R11
    {1'b0,12'hFE8,4'h2,32'h0,2'd0,32'h00000000,1'b0}, // R11
    {1'b1,12'h300,4'hF,32'hFFFFFFFF,2'd0,32'h0,1'b1}, // R12
    {1'b0,12'h008,4'hF,32'h0,2'd0,32'h0,1'b1},        // R12
    {1'b0,12'h108,4'hF,32'h0,2'd0,32'h0,1'b1},        // R12
    {1'b1,12'hFE0,4'hF,32'h0,2'd0,32'h0,1'b1},        // R12
    {1'b0,12'hF00,4'hF,32'h0,2'd0,32'h0,1'b1},        // R12
    {1'b1,12'h440,4'hF,32'h0,2'd0,32'h0,1'b1},        // R12
    {1'b0,12'h000,4'hF,32'h0,2'd0,32'h00000001,1'b0}  // R12
  };

  function automatic logic [NIRQ*NCPU-1:0] mk(input int id, input logic [3:0] m);
    logic [NIRQ*NCPU-1:0] r = '0;
    r[id*NCPU +: NCPU] = m;
    return r;
  endfunction

  task automatic check(input bit ok, input string msg, input logic [255:0] act,
                       input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", msg, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic [11:0] a, input logic [3:0] be,
                     input logic [31:0] d, input logic [1:0] cpu);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = wr; acc_waddr = a[11:2]; acc_be = be;
    acc_wdata = d; acc_cpu = cpu;
    #5;
    s_rd = acc_rdata; s_bad = acc_bad; s_set = pend_set; s_clr = pend_clr;
    @(posedge clk);
    #1 acc_en = 1'b0;
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    n_err++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NT; i++) begin
      logic [83:0] e;
      e = TBL[i];
      acc(e[83], e[82:71], e[70:67], e[66:35], e[34:33]);
      check(s_bad == e[0] && (e[83] || s_rd == e[32:1]),
            $sformatf("table entry %0d", i), {s_bad, s_rd}, {e[0], e[32:1]});
    end
    check(dist_en == 1'b1, "R2 dist_en port", dist_en, 1);

    // R4 level-triggered private ID pends for writer
    irq_level[20] = 1'b1;
    acc(1, 12'h100, 4'h4, 32'h00100000, 2'd1);
    check(s_set == mk(20, 4'b0010), "R4 private level pend", s_set, mk(20, 4'b0010));
    // R9 edge forced for private IDs
    acc(1, 12'hC04, 4'hF, 32'h0, 2'd0);
    acc(0, 12'hC04, 4'hF, 32'h0, 2'd0);
    check(s_rd == 32'hAAAAAAAA, "R9 forced edge", s_rd, 32'hAAAAAAAA);
    acc(1, 12'h180, 4'h4, 32'h00100000, 2'd1);
    acc(1, 12'h100, 4'h4, 32'h00100000, 2'd1);
    check(s_set == '0, "R4 edge ID no pend", s_set, 0);
    irq_level[20] = 1'b0;

    // R4 and R13: two level IDs enabled in one cycle
    irq_level[33] = 1'b1; irq_level[34] = 1'b1;
    acc(1, 12'h104, 4'hF, 32'h00000006, 2'd0);
    check(s_set == (mk(33, 4'hF) | mk(34, 4'hF)), "R4 shared level pend",
          s_set, mk(33, 4'hF) | mk(34, 4'hF));
    acc(0, 12'h104, 4'hF, 32'h0, 2'd0);
    check(s_rd == 32'h80000006, "R3 enable readback", s_rd, 32'h80000006);
    irq_level = '0;

    // R5 set/clear pending requests
    acc(1, 12'h200, 4'h1, 32'h04, 2'd3);
    check(s_set == mk(2, 4'b1000), "R5 set pend private", s_set, mk(2, 4'b1000));
    acc(1, 12'h204, 4'h1, 32'h02, 2'd0);
    check(s_set == mk(33, 4'hF), "R5 set pend shared", s_set, mk(33, 4'hF));
    acc(1, 12'h284, 4'hF, 32'h00000001, 2'd0);
    check(s_clr == 64'h1_0000_0000, "R5 clear pend", s_clr, 64'h1_0000_0000);

    // R6 pending/active views
    pend_state = mk(3, 4'b0010) | mk(40, 4'b0100);
    act_state  = mk(5, 4'b0001);
    acc(0, 12'h200, 4'hF, 32'h0, 2'd1);
    check(s_rd == 32'h8, "R6 own pend bit", s_rd, 32'h8);
    acc(0, 12'h200, 4'hF, 32'h0, 2'd0);
    check(s_rd == 32'h0, "R6 other cpu pend", s_rd, 32'h0);
    acc(0, 12'h284, 4'hF, 32'h0, 2'd0);
    check(s_rd == 32'h100, "R6 shared pend OR", s_rd, 32'h100);
    acc(0, 12'h300, 4'hF, 32'h0, 2'd0);
    check(s_rd == 32'h20, "R6 own active", s_rd, 32'h20);
    acc(0, 12'h300, 4'hF, 32'h0, 2'd3);
    check(s_rd == 32'h0, "R6 other active", s_rd, 32'h0);
    pend_state = '0; act_state = '0;

    // R10 software interrupt filters
    acc(1, 12'hF00, 4'hF, 32'h00050003, 2'd1);
    check(s_set == mk(3, 4'b0101), "R10 list", s_set, mk(3, 4'b0101));
    acc(1, 12'hF00, 4'hF, 32'h01000003, 2'd1);
    check(s_set == mk(3, 4'b0010), "R10 self", s_set, mk(3, 4'b0010));
    acc(1, 12'hF00, 4'hF, 32'h02000003, 2'd1);
    check(s_set == mk(3, 4'b1101), "R10 others", s_set, mk(3, 4'b1101));
    acc(1, 12'hF00, 4'hF, 32'h03000003, 2'd1);
    check(s_set == mk(3, 4'b1111), "R10 all", s_set, mk(3, 4'b1111));

    // R12 bad software interrupt accesses
    acc(1, 12'hF00, 4'hF, 32'h03000046, 2'd1);
    check(s_bad && s_set == '0, "R12 sgi id range", {s_bad, s_set}, {1'b1, 256'h0});
    acc(1, 12'hF00, 4'h1, 32'h03000003, 2'd1);
    check(s_bad && s_set == '0, "R12 sgi partial", {s_bad, s_set}, {1'b1, 256'h0});
    acc(1, 12'h300, 4'hF, 32'hFFFFFFFF, 2'd0);
    check(s_set == '0 && s_clr == '0, "R12 bad write quiet", s_set, 0);

    // R1 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    acc(0, 12'h000, 4'hF, 32'h0, 2'd0);
    check(s_rd == 32'h0 && dist_en == 1'b0, "R1 switch after reset", s_rd, 0);
    acc(0, 12'h104, 4'hF, 32'h0, 2'd0);
    check(s_rd == 32'h0, "R1 enables after reset", s_rd, 0);
    acc(0, 12'h404, 4'hF, 32'h0, 2'd0);
    check(s_rd == 32'h0, "R1 priority after reset", s_rd, 0);

    summary();
  end
endmodule